// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block schedules the background memory reads of a scanline tile renderer from the current dot number (0 to 340) of the line. Every fetch occupies two dots. On the first dot it raises a read request with the slot type and the tile position. On the second dot it takes the returned byte into one of four holding registers: tile number, palette attribute, pattern plane 0 and pattern plane 1. The four slot types always follow each other in that order, forming an 8-dot group.

During the visible part of the line the groups start at dot 1 and repeat every 8 dots up to dot 256. Each of these groups fetches tile 2 onward of the current line, because tiles 0 and 1 were fetched at the end of the previous line. Those two tiles are prefetched in groups starting at dots 321 and 329. After them come two extra tile-number reads at dots 337 and 339, whose data is thrown away. A one-dot reload strobe tells the downstream shift pipeline when the attribute and pattern holding registers carry a complete tile. When rendering is disabled the block issues no reads and no strobes, and all holding registers keep their values.

Top module: `bg_fetch_seq`

## Requirements
- R1: For a fetch dot d, let p = (d-1) mod 8. A read request is raised exactly on the dots where p is even, within dots 1 to 256 and 321 to 340. Its slot type is 0 (tile number) for p=0, 1 (attribute) for p=2, 2 (pattern plane 0) for p=4 and 3 (pattern plane 1) for p=6. All requests fall on odd dots.
- R2: On the dot after a request in dots 1 to 336, the byte on the read data input is stored, at that clock edge, into the holding register that matches the request's slot type. The bench memory answers one cycle after the request.
- R3: The tile position output is ((d-1) div 8)+2 for visible dots 1 to 256. It is 0 for the group starting at dot 321 and 1 for the group starting at dot 329.
- R4: The reload strobe is high, for one dot, on dots 9, 17, ..., 257 and on dots 329 and 337, and on no other dot.
- R5: On dots 337 and 339 a tile-number read (slot type 0) with tile position 34 is requested. The data returned on dots 338 and 340 does not change the tile-number register.
- R6: Dot 0 and dots 257 to 320 raise no request, and no holding register changes during them.
- R7: While the render enable is low, no request and no reload strobe are issued, and no holding register changes.
- R8: After reset all four holding registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot | input | 9 | Current dot within the line, 0 to 340 |
| render_en | input | 1 | Background rendering enable |
| rd_data | input | 8 | Byte returned by memory, valid on the dot after a request |
| fetch_req | output | 1 | Read request on the first dot of a slot |
| fetch_kind | output | 2 | Slot type: 0 tile number, 1 attribute, 2 pattern plane 0, 3 pattern plane 1 |
| fetch_tile | output | 6 | Tile position within the line for the current request |
| reload | output | 1 | Strobe telling the shift pipeline to take the holding registers |
| nt_byte | output | 8 | Tile-number holding register |
| at_byte | output | 8 | Attribute holding register |
| pat_lo | output | 8 | Pattern plane 0 holding register |
| pat_hi | output | 8 | Pattern plane 1 holding register |

## Verification
The dot decode is combinational, so a wrong phase or window shows at once on the request, slot type, tile position or strobe outputs in the same dot. A capture that goes into the wrong register, falls on the wrong dot, or takes place while rendering is off or in the spare reads shows on the holding register outputs one clock edge later. The bench walks every dot of enabled and disabled lines and compares every output after every dot. Each slot's memory byte depends on the slot type, the tile and the line, so a misrouted byte never matches its expected value.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  typedef enum logic [1:0] {
    SLOT_NT  = 2'd0,
    SLOT_AT  = 2'd1,
    SLOT_PLO = 2'd2,
    SLOT_PHI = 2'd3
  } slot_kind_e;

  localparam int unsigned NUM_SLOTS  = 4;
  localparam int unsigned GROUP_DOTS = 8;
endpackage

// File: rtl/bgf_rst_sync.sv
module bgf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bgf_slot_decode.sv
module bgf_slot_decode
  import bgf_pkg::*;
#(
  parameter int unsigned DOT_W       = 9,
  parameter int unsigned TILE_W      = 6,
  parameter int unsigned VIS_LAST    = 256,
  parameter int unsigned PRE_FIRST   = 321,
  parameter int unsigned SPARE_FIRST = 337,
  parameter int unsigned LINE_LAST   = 340
) (
  input  logic              render_en,
  input  logic [DOT_W-1:0]  dot,
  output logic              req,
  output slot_kind_e        kind,
  output logic [TILE_W-1:0] tile,
  output logic              cap,
  output logic              reload
);
  localparam logic [DOT_W-1:0]  D_ONE       = DOT_W'(1);
  localparam logic [DOT_W-1:0]  D_VIS_LAST  = DOT_W'(VIS_LAST);
  localparam logic [DOT_W-1:0]  D_PRE       = DOT_W'(PRE_FIRST);
  localparam logic [DOT_W-1:0]  D_SPARE     = DOT_W'(SPARE_FIRST);
  localparam logic [DOT_W-1:0]  D_LAST      = DOT_W'(LINE_LAST);
  localparam logic [DOT_W-1:0]  D_FIRST_RLD = DOT_W'(1 + GROUP_DOTS);
  localparam logic [DOT_W-1:0]  D_LAST_RLD  = DOT_W'(VIS_LAST + 1);
  localparam logic [DOT_W-1:0]  D_PRE_RLD0  = DOT_W'(PRE_FIRST + GROUP_DOTS);
  localparam logic [DOT_W-1:0]  D_PRE_RLD1  = DOT_W'(PRE_FIRST + 2 * GROUP_DOTS);
  localparam logic [TILE_W-1:0] T_VIS_BASE  = TILE_W'(2);
  localparam logic [TILE_W-1:0] T_SPARE     = TILE_W'(VIS_LAST / GROUP_DOTS + 2);

  logic [DOT_W-1:0] off;
  logic [DOT_W-1:0] pre_off;
  logic [2:0]       phase;
  logic             in_vis, in_pre, in_spare;

  always_comb begin
    off      = dot - D_ONE;
    pre_off  = dot - D_PRE;
    phase    = off[2:0];
    in_vis   = (dot >= D_ONE)   && (dot <= D_VIS_LAST);
    in_pre   = (dot >= D_PRE)   && (dot <  D_SPARE);
    in_spare = (dot >= D_SPARE) && (dot <= D_LAST);

    kind = in_spare ? SLOT_NT : slot_kind_e'(phase[2:1]);

    if (in_vis)      tile = TILE_W'(off >> 3) + T_VIS_BASE;
    else if (in_pre) tile = TILE_W'(pre_off >> 3);
    else             tile = T_SPARE;

    req = render_en && (in_vis || in_pre || in_spare) && !phase[0];
    cap = render_en && (in_vis || in_pre) && phase[0];

    reload = render_en &&
             (((dot >= D_FIRST_RLD) && (dot <= D_LAST_RLD) && (phase == 3'd0)) ||
              (dot == D_PRE_RLD0) || (dot == D_PRE_RLD1));
  end
endmodule

// File: rtl/bgf_latch_bank.sv
module bgf_latch_bank
  import bgf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  slot_kind_e        cap_kind,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] lat_out [NUM_SLOTS]
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lat
    logic              en;
    logic [DATA_W-1:0] lat_q;
    logic [DATA_W-1:0] lat_d;

    always_comb begin
      en    = cap && (cap_kind == slot_kind_e'(g));
      lat_d = en ? rd_data : lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= lat_d;
    end

    assign lat_out[g] = lat_q;
  end
endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
  import bgf_pkg::*;
#(
  parameter int unsigned DOT_W  = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TILE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic              render_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fetch_req,
  output logic [1:0]        fetch_kind,
  output logic [TILE_W-1:0] fetch_tile,
  output logic              reload,
  output logic [DATA_W-1:0] nt_byte,
  output logic [DATA_W-1:0] at_byte,
  output logic [DATA_W-1:0] pat_lo,
  output logic [DATA_W-1:0] pat_hi
);
  logic              rst_n_sync;
  logic              cap;
  slot_kind_e        kind;
  logic [DATA_W-1:0] lat [NUM_SLOTS];

  bgf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bgf_slot_decode #(
    .DOT_W  (DOT_W),
    .TILE_W (TILE_W)
  ) u_dec (
    .render_en (render_en),
    .dot       (dot),
    .req       (fetch_req),
    .kind      (kind),
    .tile      (fetch_tile),
    .cap       (cap),
    .reload    (reload)
  );

  // Captured kind equals the current dot's kind: the data dot shares the slot.
  bgf_latch_bank #(
    .DATA_W (DATA_W)
  ) u_lat (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cap      (cap),
    .cap_kind (kind),
    .rd_data  (rd_data),
    .lat_out  (lat)
  );

  assign fetch_kind = kind;
  assign nt_byte    = lat[SLOT_NT];
  assign at_byte    = lat[SLOT_AT];
  assign pat_lo     = lat[SLOT_PLO];
  assign pat_hi     = lat[SLOT_PHI];
endmodule

// File: rtl/bg_fetch_seq_chk.sv
module bg_fetch_seq_chk #(
  parameter int unsigned DOT_W  = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TILE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DOT_W-1:0]  dot,
  input logic              render_en,
  input logic              fetch_req,
  input logic [1:0]        fetch_kind,
  input logic [TILE_W-1:0] fetch_tile,
  input logic              reload,
  input logic [DATA_W-1:0] nt_byte,
  input logic [DATA_W-1:0] at_byte,
  input logic [DATA_W-1:0] pat_lo,
  input logic [DATA_W-1:0] pat_hi
);
  logic gap;
  assign gap = (dot == '0) || ((dot >= DOT_W'(257)) && (dot <= DOT_W'(320)));

  assert_req_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> dot[0]);

  assert_reload_on_nt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && (dot != DOT_W'(257))) |-> (fetch_req && (fetch_kind == 2'd0)));

  assert_spare_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dot == DOT_W'(338)) || (dot == DOT_W'(340))) |=> $stable(nt_byte));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap |-> !fetch_req);

  assert_gap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap |=> ($stable(nt_byte) && $stable(at_byte) && $stable(pat_lo) && $stable(pat_hi)));

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |-> (!fetch_req && !reload));

  assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |=> ($stable(nt_byte) && $stable(at_byte) && $stable(pat_lo) && $stable(pat_hi)));

  assert_tile_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_tile <= TILE_W'(34)));
endmodule

bind bg_fetch_seq bg_fetch_seq_chk #(
  .DOT_W  (DOT_W),
  .DATA_W (DATA_W),
  .TILE_W (TILE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dot        (dot),
  .render_en  (render_en),
  .fetch_req  (fetch_req),
  .fetch_kind (fetch_kind),
  .fetch_tile (fetch_tile),
  .reload     (reload),
  .nt_byte    (nt_byte),
  .at_byte    (at_byte),
  .pat_lo     (pat_lo),
  .pat_hi     (pat_hi)
);

// File: tb/bg_fetch_seq_tb.sv
module bg_fetch_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] dot;
  logic       render_en;
  logic [7:0] rd_data;
  logic       fetch_req;
  logic [1:0] fetch_kind;
  logic [5:0] fetch_tile;
  logic       reload;
  logic [7:0] nt_byte, at_byte, pat_lo, pat_hi;

  int n_chk  = 0;
  int n_fail = 0;
  int line   = 0;
  logic [7:0] exp_lat [4];

  always #2 clk = ~clk;

  bg_fetch_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot        (dot),
    .render_en  (render_en),
    .rd_data    (rd_data),
    .fetch_req  (fetch_req),
    .fetch_kind (fetch_kind),
    .fetch_tile (fetch_tile),
    .reload     (reload),
    .nt_byte    (nt_byte),
    .at_byte    (at_byte),
    .pat_lo     (pat_lo),
    .pat_hi     (pat_hi)
  );

  function automatic logic [7:0] mem_val(int kind, int tile, int ln);
    return 8'((kind * 64) + (tile * 3) + (ln * 17) + 5);
  endfunction

  // Behavioural memory: one-cycle read latency.
  always @(posedge clk) begin
    if (fetch_req) rd_data <= mem_val(int'(fetch_kind), int'(fetch_tile), line);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_latches(string req);
    chk(nt_byte == exp_lat[0], req, int'(nt_byte), int'(exp_lat[0]));
    chk(at_byte == exp_lat[1], req, int'(at_byte), int'(exp_lat[1]));
    chk(pat_lo  == exp_lat[2], req, int'(pat_lo),  int'(exp_lat[2]));
    chk(pat_hi  == exp_lat[3], req, int'(pat_hi),  int'(exp_lat[3]));
  endtask

  task automatic run_line(bit en);
    for (int d = 0; d <= 340; d++) begin
      bit in_vis, in_pre, in_spare, e_req, e_cap, e_rld;
      int p, e_kind, e_tile;
      @(negedge clk);
      if (d == 0 || (d >= 257 && d <= 320)) chk_latches("R6");
      else if (!en)                          chk_latches("R7");
      else if (d == 339)                     chk_latches("R5");
      else                                   chk_latches("R2");
      dot       = 9'(d);
      render_en = en;
      #1;
      p        = (d + 7) % 8;
      in_vis   = (d >= 1 && d <= 256);
      in_pre   = (d >= 321 && d <= 336);
      in_spare = (d >= 337);
      e_req    = en && (in_vis || in_pre || in_spare) && (p % 2 == 0);
      e_cap    = en && (in_vis || in_pre) && (p % 2 == 1);
      e_kind   = in_spare ? 0 : p / 2;
      e_tile   = in_vis ? (d - 1) / 8 + 2 : (in_pre ? (d - 321) / 8 : 34);
      e_rld    = en && ((d >= 9 && d <= 257 && p == 0) || d == 329 || d == 337);
      if (!en)                chk(fetch_req == 1'b0, "R7", int'(fetch_req), 0);
      else if (!e_req && (d == 0 || (d >= 257 && d <= 320)))
                              chk(fetch_req == 1'b0, "R6", int'(fetch_req), 0);
      else                    chk(fetch_req == e_req, "R1", int'(fetch_req), int'(e_req));
      if (e_req) begin
        chk(int'(fetch_kind) == e_kind, in_spare ? "R5" : "R1", int'(fetch_kind), e_kind);
        chk(int'(fetch_tile) == e_tile, in_spare ? "R5" : "R3", int'(fetch_tile), e_tile);
      end
      chk(reload == e_rld, en ? "R4" : "R7", int'(reload), int'(e_rld));
      if (e_cap) exp_lat[p / 2] = mem_val(p / 2, e_tile, line);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    dot       = '0;
    render_en = 1'b0;
    rd_data   = 8'hA5;
    for (int i = 0; i < 4; i++) exp_lat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_latches("R8");
    line = 0; run_line(1'b1);
    line = 1; run_line(1'b0);
    line = 2; run_line(1'b1);
    line = 3; run_line(1'b1);
    @(negedge clk);
    chk_latches("R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule